// File: doc/BRIEF.md
# Reset Line Supervisor with Clamp Detection

This block owns the open-drain system reset line of a microcontroller and a separate fail-safe enable output. A pulse request pulls the line low for either a short or a long interval, chosen by a length-select input. The block then lets the line go and reads its real level back through a two-stage synchronizer, so that it can tell whether the pin is following its drive.

Two pin faults are caught. The first is a line that keeps reading HIGH while it is being pulled low, which means the microcontroller cannot be reset. The second is a line that keeps reading LOW too long after release, which means the microcontroller is held in reset. Either fault moves the block into a sticky fail-safe state. In that state the line is held pulled low and the enable output is held low until a power-on reset. A 4-bit source code records why the last pulse or fault happened.

All inputs and outputs are plain level control and status pins. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `rst_supervisor`

## Requirements
- R1: While `por_n` is low, `line_drive_low` is 1, `fs_enable` is 0, `failsafe` is 0 and `src_code` is 4'b0000. After `por_n` rises, the line stays driven for exactly LONG_CYC cycles, counted from the cycle in which `por_n` goes high.
- R2: A request accepted in the idle state drives the line for exactly SHORT_CYC cycles when `long_sel` is 0, or for exactly LONG_CYC cycles when `long_sel` is 1. `long_sel` is sampled with the request, and driving begins in the cycle after the request edge.
- R3: `src_code` takes the value of `rst_cause` at the edge that starts a requested pulse. It does not change at any other time, except when a clamp fault is recorded (R6, R7).
- R4: A request has no effect on `line_drive_low` or `src_code` while a pulse is running, while the line is being watched after release, or while the block is in fail-safe.
- R5: `fs_enable` is 0 whenever the line is driven or the block is in fail-safe. In every other cycle it is 1.
- R6: If the synchronized line reads HIGH for CLAMP_HI_CYC consecutive cycles while it is being driven, the block enters fail-safe exactly CLAMP_HI_CYC cycles after the pulse starts, and `src_code` becomes 4'b1110. CLAMP_HI_CYC must be less than SHORT_CYC.
- R7: If the synchronized line reads LOW for CLAMP_LO_CYC consecutive cycles after release, the block enters fail-safe exactly CLAMP_LO_CYC cycles after release, and `src_code` becomes 4'b1101.
- R8: A line that goes HIGH again before the CLAMP_LO_CYC limit after release causes no fault. The block returns to idle with `fs_enable` high and accepts the next request.
- R9: Fail-safe is sticky. In fail-safe the line stays driven, `failsafe` stays 1, and only `por_n` low leaves the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| rst_req | input | 1 | Request a reset pulse (sampled in idle only) |
| rst_cause | input | 4 | Source code stored with an accepted request |
| long_sel | input | 1 | Pulse length select: 0 short, 1 long |
| line_in | input | 1 | Level read back from the reset pin |
| line_drive_low | output | 1 | 1 pulls the open-drain reset line low |
| fs_enable | output | 1 | Fail-safe global enable, high only when safe |
| failsafe | output | 1 | Block is in the sticky fail-safe state |
| src_code | output | 4 | Source of the last reset or fault |

## Verification
The bound checker watches every cycle for the following:
- the enable output never rises while the line is driven;
- fail-safe stays set and keeps the line driven;
- the source code changes only at the edge where a pulse starts or a fault is entered;
- a fault entry always records one of the two clamp codes.

Three behaviours are shown only by the bench scenarios: the exact pulse lengths, the exact cycles at which the two clamp timers fire, and the tolerance of a line that is released slightly late. For these the bench models the pin as tracking the drive, stuck high, or stuck low.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    ST_PULSE = 2'd0,
    ST_WATCH = 2'd1,
    ST_IDLE  = 2'd2,
    ST_FAIL  = 2'd3
  } rsv_state_e;

  localparam logic [3:0] SRC_POWER_ON   = 4'b0000;
  localparam logic [3:0] SRC_CLAMP_LOW  = 4'b1101;
  localparam logic [3:0] SRC_CLAMP_HIGH = 4'b1110;
endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rsv_run_cnt.sv
module rsv_run_cnt #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic en,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                         cnt <= '0;
    else if (!en)                       cnt <= '0;
    else if (cnt != CW'(LIMIT - 1))     cnt <= cnt + 1'b1;
  end

  assign hit = en && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/rsv_ctrl.sv
module rsv_ctrl
  import rsv_pkg::*;
#(
  parameter int SHORT_CYC = 64,
  parameter int LONG_CYC  = 512
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_req,
  input  logic [3:0] rst_cause,
  input  logic       long_sel,
  input  logic       line_high,
  input  logic       hi_fault,
  input  logic       lo_fault,
  output rsv_state_e state,
  output logic [3:0] src_code
);
  localparam int PW = $clog2(LONG_CYC + 1);

  logic [PW-1:0] pcnt;
  logic          plong;
  logic [PW-1:0] last_cnt;

  assign last_cnt = plong ? PW'(LONG_CYC - 1) : PW'(SHORT_CYC - 1);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state    <= ST_PULSE;
      pcnt     <= '0;
      plong    <= 1'b1;
      src_code <= SRC_POWER_ON;
    end else begin
      unique case (state)
        ST_PULSE: begin
          pcnt <= pcnt + 1'b1;
          if (hi_fault) begin
            state    <= ST_FAIL;
            src_code <= SRC_CLAMP_HIGH;
          end else if (pcnt == last_cnt) begin
            state <= ST_WATCH;
          end
        end
        ST_WATCH: begin
          if (lo_fault) begin
            state    <= ST_FAIL;
            src_code <= SRC_CLAMP_LOW;
          end else if (line_high) begin
            state <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (rst_req) begin
            state    <= ST_PULSE;
            pcnt     <= '0;
            plong    <= long_sel;
            src_code <= rst_cause;
          end
        end
        default: state <= ST_FAIL;
      endcase
    end
  end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rsv_pkg::*;
#(
  parameter int SHORT_CYC    = 64,
  parameter int LONG_CYC     = 512,
  parameter int CLAMP_HI_CYC = 32,
  parameter int CLAMP_LO_CYC = 256,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_req,
  input  logic [3:0] rst_cause,
  input  logic       long_sel,
  input  logic       line_in,
  output logic       line_drive_low,
  output logic       fs_enable,
  output logic       failsafe,
  output logic [3:0] src_code
);
  localparam int NUM_MON = 2;

  rsv_state_e         state;
  logic               line_high;
  logic [NUM_MON-1:0] mon_en;
  logic [NUM_MON-1:0] mon_hit;

  rsv_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .por_n (por_n),
    .d     (line_in),
    .q     (line_high)
  );

  // index 0: stuck HIGH while pulled low; index 1: stuck LOW after release
  assign mon_en[0] = (state == ST_PULSE) && line_high;
  assign mon_en[1] = (state == ST_WATCH) && !line_high;

  for (genvar g = 0; g < NUM_MON; g++) begin : g_mon
    localparam int LIM = (g == 0) ? CLAMP_HI_CYC : CLAMP_LO_CYC;
    rsv_run_cnt #(.LIMIT(LIM)) i_run (
      .clk   (clk),
      .por_n (por_n),
      .en    (mon_en[g]),
      .hit   (mon_hit[g])
    );
  end

  rsv_ctrl #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) i_ctrl (
    .clk       (clk),
    .por_n     (por_n),
    .rst_req   (rst_req),
    .rst_cause (rst_cause),
    .long_sel  (long_sel),
    .line_high (line_high),
    .hi_fault  (mon_hit[0]),
    .lo_fault  (mon_hit[1]),
    .state     (state),
    .src_code  (src_code)
  );

  assign line_drive_low = (state == ST_PULSE) || (state == ST_FAIL);
  assign failsafe       = (state == ST_FAIL);
  assign fs_enable      = (state == ST_IDLE) || (state == ST_WATCH);
endmodule

// File: rtl/rsv_chk.sv
module rsv_chk
  import rsv_pkg::*;
(
  input logic       clk,
  input logic       por_n,
  input logic       rst_req,
  input logic       drive_low,
  input logic       fs_enable,
  input logic       failsafe,
  input logic [3:0] src_code
);
  // R5
  drive_blocks_enable_chk: assert property (@(posedge clk) disable iff (!por_n)
    drive_low |-> !fs_enable);

  // R9
  failsafe_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    failsafe |=> failsafe);

  // R9
  failsafe_drives_chk: assert property (@(posedge clk) disable iff (!por_n)
    failsafe |-> drive_low);

  // R3
  src_stable_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!$rose(drive_low) && !$rose(failsafe)) |-> $stable(src_code));

  // R6
  fault_code_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(failsafe) |-> (src_code == SRC_CLAMP_LOW || src_code == SRC_CLAMP_HIGH));

  // R4
  fail_ignores_req_chk: assert property (@(posedge clk) disable iff (!por_n)
    (failsafe && rst_req) |=> $stable(src_code));
endmodule

bind rst_supervisor rsv_chk i_chk (
  .clk       (clk),
  .por_n     (por_n),
  .rst_req   (rst_req),
  .drive_low (line_drive_low),
  .fs_enable (fs_enable),
  .failsafe  (failsafe),
  .src_code  (src_code)
);

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int SHORT = 8, LONG = 20, CHI = 6, CLO = 10;

  logic clk = 0, por_n = 0, rst_req = 0, long_sel = 0;
  logic [3:0] rst_cause = 0;
  logic stuck_lo = 0, stuck_hi = 0;
  logic line_in, line_drive_low, fs_enable, failsafe;
  logic [3:0] src_code;
  int tests = 0, fails = 0;
  bit done = 0;

  assign line_in = stuck_lo ? 1'b0 : (stuck_hi ? 1'b1 : ~line_drive_low);

  rst_supervisor #(.SHORT_CYC(SHORT), .LONG_CYC(LONG), .CLAMP_HI_CYC(CHI),
                   .CLAMP_LO_CYC(CLO)) i_rst_supervisor (
    .clk(clk), .por_n(por_n), .rst_req(rst_req), .rst_cause(rst_cause),
    .long_sel(long_sel), .line_in(line_in), .line_drive_low(line_drive_low),
    .fs_enable(fs_enable), .failsafe(failsafe), .src_code(src_code));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_width(input bit lng);
    return lng ? LONG : SHORT;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(output int w, output bit en_bad);
    w = 0; en_bad = 0;
    while (line_drive_low && w < 5000) begin
      if (fs_enable) en_bad = 1;
      w++;
      @(negedge clk);
    end
  endtask

  task automatic request(input logic [3:0] c, input bit lng);
    @(negedge clk);
    rst_req = 1; rst_cause = c; long_sel = lng;
    @(negedge clk);
    rst_req = 0;
  endtask

  task automatic do_por();
    int w; bit eb;
    @(negedge clk);
    stuck_lo = 0; stuck_hi = 0; por_n = 0;
    repeat (2) @(negedge clk);
    chk(line_drive_low == 1 && fs_enable == 0 && failsafe == 0, "R1 reset outputs",
        {line_drive_low, fs_enable, failsafe}, 3'b100);
    chk(src_code == 4'b0000, "R1 reset src", src_code, 0);
    por_n = 1;
    measure(w, eb);
    chk(w == LONG, "R1 power-on pulse width", w, LONG);
    repeat (4) @(negedge clk);
    chk(fs_enable == 1, "R5 enable after power-on", fs_enable, 1);
  endtask

  task automatic normal_pulse(input logic [3:0] c, input bit lng, input bit extra);
    int w; bit eb;
    request(c, lng);
    if (extra) begin
      rst_req = 1; rst_cause = ~c; long_sel = ~lng;
      @(negedge clk);
      rst_req = 0;
      measure(w, eb);
      w = w + 1;
    end else measure(w, eb);
    chk(w == exp_width(lng), extra ? "R4 width unchanged by extra request" : "R2 pulse width",
        w, exp_width(lng));
    chk(!eb, "R5 enable low while driven", eb, 0);
    chk(src_code == c, extra ? "R4 src unchanged" : "R3 src captured", src_code, c);
    repeat (4) @(negedge clk);
  endtask

  initial begin : main
    int w; bit eb;
    void'($urandom(32'h5eed));
    do_por();

    normal_pulse(4'h3, 0, 0);
    normal_pulse(4'h9, 1, 0);
    normal_pulse(4'h5, 0, 1);
    normal_pulse(4'hA, 1, 1);

    // R4: request during watch window after release
    request(4'h7, 0);
    measure(w, eb);
    rst_req = 1; rst_cause = 4'h1;
    @(negedge clk);
    rst_req = 0;
    eb = 0;
    repeat (4) begin if (line_drive_low) eb = 1; @(negedge clk); end
    chk(!eb, "R4 request in watch ignored", eb, 0);
    chk(src_code == 4'h7, "R4 src kept in watch", src_code, 7);

    for (int i = 0; i < 30; i++) begin
      normal_pulse(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
                   ($urandom_range(0, 3) == 0));
    end

    // R8: late release shorter than the limit
    stuck_lo = 1;
    request(4'h2, 0);
    measure(w, eb);
    repeat (CLO - 4) @(negedge clk);
    stuck_lo = 0;
    repeat (5) @(negedge clk);
    chk(failsafe == 0 && fs_enable == 1, "R8 no fault on brief low", failsafe, 0);
    normal_pulse(4'h4, 0, 0);

    // R7: stuck low after release
    stuck_lo = 1;
    request(4'h6, 0);
    measure(w, eb);
    repeat (CLO - 1) @(negedge clk);
    chk(failsafe == 0, "R7 no fault before limit", failsafe, 0);
    @(negedge clk);
    chk(failsafe == 1, "R7 fault at limit", failsafe, 1);
    chk(src_code == 4'b1101, "R7 clamp-low code", src_code, 4'b1101);

    // R9: sticky, requests ignored
    stuck_lo = 0;
    rst_req = 1; rst_cause = 4'h8;
    @(negedge clk);
    rst_req = 0;
    repeat (30) @(negedge clk);
    chk(failsafe == 1 && line_drive_low == 1 && fs_enable == 0, "R9 sticky fail-safe",
        {failsafe, line_drive_low, fs_enable}, 3'b110);
    chk(src_code == 4'b1101, "R4 src kept in fail-safe", src_code, 4'b1101);

    do_por();

    // R6: stuck high while driving
    stuck_hi = 1;
    request(4'hB, 0);
    repeat (CHI - 1) @(negedge clk);
    chk(failsafe == 0, "R6 no fault before limit", failsafe, 0);
    @(negedge clk);
    chk(failsafe == 1, "R6 fault at limit", failsafe, 1);
    chk(src_code == 4'b1110, "R6 clamp-high code", src_code, 4'b1110);
    repeat (LONG) @(negedge clk);
    chk(line_drive_low == 1 && fs_enable == 0, "R9 drive held", line_drive_low, 1);

    do_por();
    normal_pulse(4'hC, 1, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule